// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a clocked request port and an asynchronous 32K x 8 static RAM. A client presents an address, a direction flag and, for stores, a data byte, together with a one-clock request. The sequencer then drives the memory's active-low chip enable, write enable and output enable, its 15-bit address and its 8-bit data bus. Every minimum width is met by counting whole clocks. When the access is finished it raises a one-clock ready, and for loads the captured byte is on the read-data port in that same clock.

All timing is set by parameters: the clock period and the memory's cycle time, write pulse width and output float time, each in nanoseconds. The sequencer rounds each one up to whole clocks, so one netlist covers both the 55 ns and the 70 ns speed grades. The write window is framed by write enable inside an already-low chip enable. Output enable stays high for the whole store. The controller's own bus drivers are switched on only after output enable has been high long enough for the memory's outputs to float. Between accesses chip enable is high, which keeps the memory in its low-power deselected state.

Top module: `sram_seq_ctrl`

## Requirements
- R1: Out of reset and between accesses mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and ready is 0.
- R2: A load (req=1 with req_write=0, taken while idle) holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RC_CLKS clocks (ceil(CYCLE_NS/CLK_NS), 14 by default). rdata then equals the byte the memory presents at the end of the last of those clocks.
- R3: A store (req=1 with req_write=1) drives mem_we_n low for exactly WP_CLKS clocks (ceil(WPULSE_NS/CLK_NS), 8 by default), always while mem_ce_n is 0 and mem_oe_n is 1.
- R4: Every interval with mem_ce_n low lasts at least RC_CLKS clocks.
- R5: mem_addr changes only in the clock an access is accepted, and then only while mem_we_n is 1 and mem_ce_n was 1 in the clock before. It holds throughout the access.
- R6: mem_dq_oe is 1 only while mem_oe_n is 1. It rises only after mem_oe_n has been 1 for at least TURN_CLKS clocks (ceil(OFF_NS/CLK_NS), 6 by default). It stays 1 through the whole write pulse and one clock beyond, and mem_dq_o then carries the accepted write byte.
- R7: ready is 1 for exactly one clock. It comes RC_CLKS+1 clocks after a load is accepted, and (RC_CLKS-WP_CLKS)+WP_CLKS+2 clocks after a store is accepted (16 by default).
- R8: A request raised while an access is in progress is ignored: it causes no ready pulse and no memory cycle.
- R9: A byte stored to an address is returned by every later load of that address until it is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to store |
| ready | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Byte captured by the last load |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data returned by the memory |

## Verification
A wrong state or a wrong wait count shows up at the memory pins within the same access. If the load counter ends one clock early, the byte is captured before the memory model's access time has elapsed, and rdata carries the model's filler value at the ready pulse. A short write pulse or a late turnaround guard shows up as a strobe width or drive-enable timing that the pin monitor flags at the strobe edge itself. Lost or misdirected stores show up on the later read-back sweep over addresses spread across the whole space, including both ends.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RACC = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_WREC = 3'd4,
    ST_DONE = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STROBE_PARK = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Pin levels that belong to each sequencer state.
  function automatic strobe_t strobe_for(input seq_state_e st);
    strobe_t s;
    s = STROBE_PARK;
    case (st)
      ST_RACC: begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
      ST_WSET: begin s.ce_n = 1'b0; end
      ST_WPUL: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.drv = 1'b1; end
      ST_WREC: begin s.ce_n = 1'b0; s.drv = 1'b1; end
      default: s = STROBE_PARK;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_turn_guard.sv
`timescale 1ns/1ps
module sram_turn_guard #(
  parameter int TURN_CLKS = 6,
  parameter int CNT_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  output logic bus_free
);

  localparam logic [CNT_W-1:0] SAT  = CNT_W'(TURN_CLKS);
  localparam logic [CNT_W-1:0] NEED = CNT_W'(TURN_CLKS - 1);

  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] hi_d;
  logic             hi_en;

  always_comb begin
    hi_en = !oe_n ? (hi_q != '0) : (hi_q != SAT);
    hi_d  = !oe_n ? '0 : (hi_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  // The decision clock itself is one more clock with output enable high.
  assign bus_free = oe_n && (hi_q >= NEED);

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= addr_in;
      dq_out   <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= dq_in;
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int CYCLE_NS  = 70,
  parameter int WPULSE_NS = 40,
  parameter int OFF_NS    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RC_CLKS   = int'(ceil_div(CYCLE_NS, CLK_NS));
  localparam int WP_CLKS   = int'(ceil_div(WPULSE_NS, CLK_NS));
  localparam int TURN_RAW  = int'(ceil_div(OFF_NS, CLK_NS));
  localparam int TURN_CLKS = (TURN_RAW < 1) ? 1 : TURN_RAW;
  localparam int SET_CLKS  = (RC_CLKS > WP_CLKS) ? (RC_CLKS - WP_CLKS) : 1;
  localparam int MAX_CLKS  = (RC_CLKS > WP_CLKS) ? RC_CLKS : WP_CLKS;
  localparam int CNT_W     = $clog2(MAX_CLKS + 1);
  localparam int TURN_W    = $clog2(TURN_CLKS + 1);

  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RC_CLKS - 1);
  localparam logic [CNT_W-1:0] SET_LOAD = CNT_W'(SET_CLKS - 1);
  localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CLKS - 1);

  seq_state_e       state_q, state_d;
  strobe_t          strobe_q, strobe_d;
  logic             ready_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             bus_free;
  logic             accept;
  logic             capture;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WSET;
          tmr_val = SET_LOAD;
        end else begin
          state_d = ST_RACC;
          tmr_val = RD_LOAD;
        end
      end
      ST_RACC: if (tmr_done) begin
        capture = 1'b1;
        state_d = ST_DONE;
      end
      ST_WSET: if (tmr_done && bus_free) begin
        tmr_load = 1'b1;
        tmr_val  = WP_LOAD;
        state_d  = ST_WPUL;
      end
      ST_WPUL: if (tmr_done) state_d = ST_WREC;
      ST_WREC: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    strobe_d = strobe_for(state_d);
  end

  // State and pin registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      strobe_q <= STROBE_PARK;
      ready_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
      ready_q  <= (state_d == ST_DONE);
    end
  end

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_turn_guard #(.TURN_CLKS(TURN_CLKS), .CNT_W(TURN_W)) u_turn (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (strobe_q.oe_n),
    .bus_free (bus_free)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .capture  (capture),
    .dq_in    (mem_dq_i),
    .mem_addr (mem_addr),
    .dq_out   (mem_dq_o),
    .rdata    (rdata)
  );

  assign ready     = ready_q;
  assign mem_ce_n  = strobe_q.ce_n;
  assign mem_we_n  = strobe_q.we_n;
  assign mem_oe_n  = strobe_q.oe_n;
  assign mem_dq_oe = strobe_q.drv;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sram_seq_ctrl_chk #(
  parameter int ADDR_W    = 15,
  parameter int RC_CLKS   = 14,
  parameter int WP_CLKS   = 8,
  parameter int TURN_CLKS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [15:0] we_lo_cnt;
  logic [15:0] ce_lo_cnt;
  logic [15:0] oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      ce_lo_cnt <= '0;
      oe_hi_cnt <= '0;
    end else begin
      we_lo_cnt <= we_n ? 16'd0 : ((we_lo_cnt == 16'hFFFF) ? we_lo_cnt : we_lo_cnt + 16'd1);
      ce_lo_cnt <= ce_n ? 16'd0 : ((ce_lo_cnt == 16'hFFFF) ? ce_lo_cnt : ce_lo_cnt + 16'd1);
      oe_hi_cnt <= !oe_n ? 16'd0 : ((oe_hi_cnt == 16'hFFFF) ? oe_hi_cnt : oe_hi_cnt + 16'd1);
    end
  end

  // R1
  park_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && we_n && oe_n && !dq_oe));

  // R2
  read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));

  // R3
  write_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n && dq_oe));

  // R3
  write_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_lo_cnt == 16'(WP_CLKS)));

  // R4
  select_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> (ce_lo_cnt >= 16'(RC_CLKS)));

  // R5
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> (we_n && $past(ce_n)));

  // R6
  drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (oe_hi_cnt >= 16'(TURN_CLKS)));

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .RC_CLKS   (RC_CLKS),
  .WP_CLKS   (WP_CLKS),
  .TURN_CLKS (TURN_CLKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .ce_n     (mem_ce_n),
  .we_n     (mem_we_n),
  .oe_n     (mem_oe_n),
  .dq_oe    (mem_dq_oe),
  .mem_addr (mem_addr)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;

  localparam int RC   = (70 + 5 - 1) / 5;
  localparam int WP   = (40 + 5 - 1) / 5;
  localparam int TURN = (30 + 5 - 1) / 5;
  localparam int RD_LAT = RC + 1;
  localparam int WR_LAT = (RC - WP) + WP + 2;

  logic       clk;
  logic       rst_n;
  logic       req;
  logic       req_write;
  logic [14:0] req_addr;
  logic [7:0] req_wdata;
  logic       ready;
  logic [7:0] rdata;
  logic       mem_ce_n, mem_we_n, mem_oe_n;
  logic [14:0] mem_addr;
  logic [7:0] mem_dq_o;
  logic       mem_dq_oe;
  logic [7:0] mem_dq_i;

  int n_vec;
  int n_mis;

  logic [7:0] mem_model [int];
  logic [7:0] exp_mem   [int];

  sram_seq_ctrl u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural memory and pin monitor, evaluated mid-cycle.
  int          rd_age, we_age, ce_age, oe_hi;
  logic [14:0] rd_addr_last, wr_addr_last;
  logic [7:0]  wr_data_last;
  logic        dq_oe_last;

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_age = 0; we_age = 0; ce_age = 0; oe_hi = 0;
      dq_oe_last = 1'b0;
      mem_dq_i <= 8'h5A;
    end else begin
      // load access timing of the modelled memory
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        if (rd_age > 0 && mem_addr != rd_addr_last) rd_age = 1;
        else rd_age++;
        rd_addr_last = mem_addr;
      end else rd_age = 0;
      if (rd_age >= RC)
        mem_dq_i <= mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)] : 8'h00;
      else
        mem_dq_i <= 8'h5A;

      // store window
      if (!mem_ce_n && !mem_we_n) begin
        if (we_age > 0) begin
          check(mem_addr == wr_addr_last, "R5 addr moved in write", int'(mem_addr), int'(wr_addr_last));
          check(mem_dq_o == wr_data_last, "R6 data moved in write", int'(mem_dq_o), int'(wr_data_last));
        end
        check(mem_oe_n && mem_dq_oe, "R3 oe/drive in write", int'({mem_oe_n, mem_dq_oe}), 3);
        we_age++;
        wr_addr_last = mem_addr;
        wr_data_last = mem_dq_o;
      end else if (we_age > 0) begin
        check(we_age == WP, "R3 write pulse width", we_age, WP);
        check(mem_dq_oe, "R6 data hold after pulse", int'(mem_dq_oe), 1);
        mem_model[int'(wr_addr_last)] = wr_data_last;
        we_age = 0;
      end

      // select width
      if (!mem_ce_n) ce_age++;
      else if (ce_age > 0) begin
        check(ce_age >= RC, "R4 select width", ce_age, RC);
        ce_age = 0;
      end

      // bus drive versus output enable
      if (mem_dq_oe && !mem_oe_n) check(1'b0, "R6 drive while oe low", 1, 0);
      if (mem_dq_oe && !dq_oe_last) check(oe_hi >= TURN, "R6 turnaround", oe_hi, TURN);
      dq_oe_last = mem_dq_oe;
      if (mem_oe_n) oe_hi++;
      else oe_hi = 0;
    end
  end

  task automatic check_park(input string tag);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ready, tag,
          int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}), 5'b11100);
  endtask

  task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        input bit intrude);
    int lat;
    @(negedge clk);
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!ready && lat < 64) begin
      if (intrude && lat == 3) begin
        req = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      end else req = 1'b0;
      @(negedge clk);
      lat++;
    end
    req = 1'b0;
    if (wr) begin
      check(lat == WR_LAT, "R7 store latency", lat, WR_LAT);
      exp_mem[int'(a)] = d;
    end else begin
      check(lat == RD_LAT, "R7 load latency", lat, RD_LAT);
      check(rdata == (exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00),
            "R2 R9 load data", int'(rdata),
            exp_mem.exists(int'(a)) ? int'(exp_mem[int'(a)]) : 0);
    end
    @(negedge clk);
    check_park("R1 R7 park after ready");
  endtask

  function automatic logic [14:0] sweep_addr(input int i);
    if (i == 0) return 15'h0000;
    if (i == 63) return 15'h7FFF;
    return 15'((i * 517 + (i % 7)) & 16'h7FFF);
  endfunction

  initial begin
    n_vec = 0; n_mis = 0;
    rst_n = 1'b0; req = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_park("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_park("R1 idle after reset");

    // fill pass, then read back
    for (int i = 0; i < 64; i++) access(1'b1, sweep_addr(i), 8'((i * 37 + 11) & 255), 1'b0);
    for (int i = 0; i < 64; i++) access(1'b0, sweep_addr(i), 8'h00, 1'b0);

    // store then immediate load of the same address, complemented data
    for (int i = 0; i < 64; i++) begin
      access(1'b1, sweep_addr(i), ~8'((i * 37 + 11) & 255), 1'b0);
      access(1'b0, sweep_addr(i), 8'h00, 1'b0);
    end

    // all data values at the top and bottom addresses
    for (int v = 0; v < 256; v += 17) begin
      access(1'b1, 15'h7FFF, 8'(v), 1'b0);
      access(1'b1, 15'h0000, ~8'(v), 1'b0);
      access(1'b0, 15'h7FFF, 8'h00, 1'b0);
      access(1'b0, 15'h0000, 8'h00, 1'b0);
    end

    // R8: a request raised mid-access must not start a second cycle
    access(1'b1, 15'h1234, 8'hC3, 1'b1);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      check(!ready && mem_ce_n, "R8 intruding request ignored",
            int'({ready, mem_ce_n}), 1);
    end
    access(1'b0, 15'h1234, 8'h00, 1'b0);
    access(1'b0, ~15'h1234, 8'h00, 1'b0);
    access(1'b0, 15'h1234, 8'h00, 1'b1);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      check(!ready && mem_ce_n, "R8 intruding request ignored after load",
            int'({ready, mem_ce_n}), 1);
    end
    access(1'b0, ~15'h1234, 8'h00, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
    $finish;
  end

endmodule